// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Edge Interrupts

This block is a byte-addressed register bank that drives three groups of pins. Eight bidirectional pins can be outputs, or inputs that raise interrupts. Six switched outputs each carry a drive-strength code. Eight plain outputs share one byte. A simple synchronous byte bus reaches every register: an address, write data, a write strobe, a read strobe and combinational read data.

Each bidirectional input passes through a two-flop synchronizer and then a per-pin debounce filter. The filter counts pulses of a clock-enable tick, and only then is a new level accepted. When a pin's accepted level rises or falls, and that edge is enabled in the pin's control byte, the pin's bit in a shared status byte is set. The status byte clears when it is read. The single interrupt line is high while any status bit is set.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register is 0x00. All pin outputs, output enables, strength codes, `irq` and `busRdata` are 0, and the accepted input levels are 0.
- R2: The bidirectional control byte for pin n (0..7) is at 0xE0+n. Its bits are: 0 drive enable, 1 direction (1 = input), 2 accepted pin level (read-only; written values are ignored), 3 output value, 4 falling-edge interrupt enable, 5 rising-edge interrupt enable, 7:6 debounce select. All bits except bit 2 read back as written.
- R3: `ioOe[n]` is 1 only when bit 0 of pin n's byte is 1 and bit 1 is 0. `ioOut[n]` equals bit 3 of that byte.
- R4: Inputs are synchronized by two flops. With debounce select 0, a level present on `ioIn[n]` before clock edge k shows in bit 2 after edge k+2.
- R5: Debounce select values 0, 1, 2 and 3 require 0, 2, 4 and 8 `dbTick` pulses. For those pulses the synchronized level must differ from the accepted level before the new level is accepted. Any cycle where the two agree restarts the count.
- R6: A rise of the accepted level sets status bit n when bit 5 is 1. A fall sets it when bit 4 is 1. Both may be enabled at once.
- R7: The status byte is at 0xE8 and is read-only. A read returns it and clears it at the same clock edge. An event accepted in that same cycle stays set.
- R8: `irq` is 1 exactly when any status bit is 1.
- R9: The switched-output byte for output m (0..5) is at 0xEC+m. Bit 0 drives `swOe[m]`, bit 3 drives `swOut[m]`, and bits 5:4 drive `swStrength[2m+1:2m]`. Its other bits read as 0.
- R10: The plain-output byte is at 0xF4. Bit n drives `plainOut[n]`, and the byte reads back as written.
- R11: `busRdata` is 0x00 whenever `busRd` is 0, and also for reads of unmapped addresses. Writes to unmapped addresses, and to 0xE8, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dbTick | input | 1 | Clock-enable tick that paces the debounce counters |
| busAddr | input | 8 | Register byte address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (also clears the status byte when it addresses it) |
| busRdata | output | 8 | Combinational read data |
| ioIn | input | 8 | Sampled levels of the bidirectional pins |
| ioOut | output | 8 | Output values of the bidirectional pins |
| ioOe | output | 8 | Output enables of the bidirectional pins |
| swOut | output | 6 | Switched output values |
| swOe | output | 6 | Switched output enables |
| swStrength | output | 12 | Drive-strength code, two bits per switched output |
| plainOut | output | 8 | Plain outputs |
| irq | output | 1 | Interrupt, OR of the status bits |

## Verification
Several properties are checked on every cycle. The interrupt line must agree with any status byte that is read out. The status byte must stay set until it is read. A write to the plain and switched registers must appear on the pins one cycle later. A bidirectional pin's output enable must match its readback. Read data must be zero when there is no read or the address is unmapped. Other behaviour needs the bench's reference model run through long stimulus. That includes the synchronizer latency, the debounce counts for each select value with glitches that restart them, edge capture for each enable combination, and the edge that lands in the same cycle as a status read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  parameter int AW = 8;
  parameter int DW = 8;
  parameter int NB = 8;   // bidirectional pins
  parameter int NS = 6;   // switched outputs
  parameter int CW = 4;   // debounce counter width

  parameter logic [AW-1:0] PIN_BASE   = 8'hE0;
  parameter logic [AW-1:0] STAT_ADDR  = 8'hE8;
  parameter logic [AW-1:0] SW_BASE    = 8'hEC;
  parameter logic [AW-1:0] PLAIN_ADDR = 8'hF4;

  // bit positions inside a bidirectional control byte
  localparam int B_DRV  = 0;
  localparam int B_DIR  = 1;
  localparam int B_LVL  = 2;
  localparam int B_OUT  = 3;
  localparam int B_FALL = 4;
  localparam int B_RISE = 5;
  localparam int B_DB   = 6;

  localparam logic [DW-1:0] PIN_MASK = 8'hFB;
  localparam logic [DW-1:0] SW_MASK  = 8'h39;

  typedef struct packed {
    logic [NB-1:0] pinWr;
    logic [NS-1:0] swWr;
    logic          plainWr;
    logic          statClr;
  } bankStrobe_t;

  function automatic logic [CW-1:0] dbNeed(input logic [1:0] sel);
    return (sel == 2'd0) ? '0 : CW'(1) << sel;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [AW-1:0]         busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [NB-1:0][DW-1:0] pinView,
  input  logic [NS-1:0][DW-1:0] swView,
  input  logic [DW-1:0]         plainView,
  input  logic [DW-1:0]         statView,
  output bankStrobe_t           stb,
  output logic [DW-1:0]         busRdata
);
  logic [DW-1:0] rdSel;

  always_comb begin
    stb   = '0;
    rdSel = '0;
    for (int i = 0; i < NB; i++) begin
      if (busAddr == (PIN_BASE + AW'(i))) begin
        stb.pinWr[i] = busWr;
        rdSel        = pinView[i];
      end
    end
    for (int i = 0; i < NS; i++) begin
      if (busAddr == (SW_BASE + AW'(i))) begin
        stb.swWr[i] = busWr;
        rdSel       = swView[i];
      end
    end
    if (busAddr == PLAIN_ADDR) begin
      stb.plainWr = busWr;
      rdSel       = plainView;
    end
    if (busAddr == STAT_ADDR) begin
      stb.statClr = busRd;
      rdSel       = statView;
    end
  end

  assign busRdata = busRd ? rdSel : '0;
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dbTick,
  input  bankStrobe_t           stb,
  input  logic [DW-1:0]         busWdata,
  input  logic [NB-1:0]         ioIn,
  output logic [NB-1:0][DW-1:0] pinView,
  output logic [NS-1:0][DW-1:0] swView,
  output logic [DW-1:0]         plainView,
  output logic [DW-1:0]         statView,
  output logic [NB-1:0]         ioOut,
  output logic [NB-1:0]         ioOe,
  output logic [NS-1:0]         swOut,
  output logic [NS-1:0]         swOe,
  output logic [2*NS-1:0]       swStrength,
  output logic [DW-1:0]         plainOut,
  output logic                  irq
);
  logic [NB-1:0] syncA, syncB;
  logic [NB-1:0] evt;
  logic [DW-1:0] plainReg, statReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= ioIn;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_pin
    logic [DW-1:0] ctl;
    logic          lvl, nxtLvl;
    logic [CW-1:0] cnt, nxtCnt, need;

    always_comb begin
      need   = dbNeed(ctl[B_DB+1:B_DB]);
      nxtLvl = lvl;
      nxtCnt = cnt;
      if (syncB[g] == lvl) begin
        nxtCnt = '0;
      end else if (need == '0) begin
        nxtLvl = syncB[g];
      end else if (dbTick) begin
        if ((cnt + CW'(1)) >= need) begin
          nxtLvl = syncB[g];
          nxtCnt = '0;
        end else begin
          nxtCnt = cnt + CW'(1);
        end
      end
    end

    assign evt[g] = (nxtLvl & ~lvl & ctl[B_RISE]) | (~nxtLvl & lvl & ctl[B_FALL]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctl <= '0;
        lvl <= 1'b0;
        cnt <= '0;
      end else begin
        if (stb.pinWr[g]) ctl <= busWdata & PIN_MASK;
        lvl <= nxtLvl;
        cnt <= nxtCnt;
      end
    end

    assign pinView[g] = {ctl[DW-1:B_LVL+1], lvl, ctl[B_LVL-1:0]};
    assign ioOe[g]    = ctl[B_DRV] & ~ctl[B_DIR];
    assign ioOut[g]   = ctl[B_OUT];
  end

  for (genvar g = 0; g < NS; g++) begin : g_sw
    logic [DW-1:0] ctl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctl <= '0;
      else if (stb.swWr[g]) ctl <= busWdata & SW_MASK;
    end
    assign swView[g]          = ctl;
    assign swOe[g]            = ctl[0];
    assign swOut[g]           = ctl[3];
    assign swStrength[2*g +: 2] = ctl[5:4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      plainReg <= '0;
      statReg  <= '0;
    end else begin
      if (stb.plainWr) plainReg <= busWdata;
      statReg <= (statReg & ~{DW{stb.statClr}}) | DW'(evt);
    end
  end

  assign plainView = plainReg;
  assign plainOut  = plainReg;
  assign statView  = statReg;
  assign irq       = |statReg;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          dbTick,
  input  logic [7:0]    busAddr,
  input  logic [7:0]    busWdata,
  input  logic          busWr,
  input  logic          busRd,
  output logic [7:0]    busRdata,
  input  logic [7:0]    ioIn,
  output logic [7:0]    ioOut,
  output logic [7:0]    ioOe,
  output logic [5:0]    swOut,
  output logic [5:0]    swOe,
  output logic [11:0]   swStrength,
  output logic [7:0]    plainOut,
  output logic          irq
);
  bankStrobe_t           stb;
  logic [NB-1:0][DW-1:0] pinView;
  logic [NS-1:0][DW-1:0] swView;
  logic [DW-1:0]         plainView, statView;

  gpio_bank_ctrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .pinView(pinView), .swView(swView), .plainView(plainView), .statView(statView),
    .stb(stb), .busRdata(busRdata)
  );

  gpio_bank_dp u_dp (
    .clk(clk), .rstN(rstN), .dbTick(dbTick), .stb(stb), .busWdata(busWdata),
    .ioIn(ioIn), .pinView(pinView), .swView(swView), .plainView(plainView),
    .statView(statView), .ioOut(ioOut), .ioOe(ioOe), .swOut(swOut), .swOe(swOe),
    .swStrength(swStrength), .plainOut(plainOut), .irq(irq)
  );
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic [7:0]  busWdata,
  input logic        busWr,
  input logic        busRd,
  input logic [7:0]  busRdata,
  input logic [7:0]  ioOe,
  input logic [5:0]  swOut,
  input logic [5:0]  swOe,
  input logic [7:0]  plainOut,
  input logic        irq
);
  logic mapped;
  assign mapped = (busAddr >= PIN_BASE && busAddr <= STAT_ADDR) ||
                  (busAddr >= SW_BASE && busAddr < SW_BASE + AW'(NS)) ||
                  (busAddr == PLAIN_ADDR);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> busRdata == 8'h00);

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !mapped) |-> busRdata == 8'h00);

  a_r8_irq_matches_status: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == STAT_ADDR) |-> irq == (busRdata != 8'h00));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(busRd && busAddr == STAT_ADDR)) |=> irq);

  a_r10_plain_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == PLAIN_ADDR) |=> plainOut == $past(busWdata));

  a_r9_switched_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == SW_BASE) |=> (swOe[0] == $past(busWdata[0]) && swOut[0] == $past(busWdata[3])));

  a_r3_oe_readback: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == PIN_BASE) |-> ioOe[0] == (busRdata[B_DRV] & ~busRdata[B_DIR]));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
  .busRd(busRd), .busRdata(busRdata), .ioOe(ioOe), .swOut(swOut), .swOe(swOe),
  .plainOut(plainOut), .irq(irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  logic clk = 0, rstN = 0, dbTick = 0;
  logic [7:0] busAddr = 0, busWdata = 0, ioIn = 0;
  logic busWr = 0, busRd = 0;
  logic [7:0] busRdata, ioOut, ioOe, plainOut;
  logic [5:0] swOut, swOe;
  logic [11:0] swStrength;
  logic irq;

  always #2 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rstN(rstN), .dbTick(dbTick), .busAddr(busAddr), .busWdata(busWdata),
    .busWr(busWr), .busRd(busRd), .busRdata(busRdata), .ioIn(ioIn), .ioOut(ioOut),
    .ioOe(ioOe), .swOut(swOut), .swOe(swOe), .swStrength(swStrength),
    .plainOut(plainOut), .irq(irq)
  );

  int nChk = 0, nFail = 0, cyc = 0, tickCnt = 0;
  string curTag = "R1";

  // behavioural reference model
  logic [7:0] mPin [8];
  logic [7:0] mSw [6];
  int         mCnt [8];
  logic [7:0] mLvl, mS1, mS2, mPlain, mStat, ev;

  always @(posedge clk) begin
    tickCnt <= (tickCnt == 2) ? 0 : tickCnt + 1;
    dbTick  <= (tickCnt == 1);
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (mPin[i]) begin mPin[i] = 0; mCnt[i] = 0; end
      foreach (mSw[i]) mSw[i] = 0;
      mLvl = 0; mS1 = 0; mS2 = 0; mPlain = 0; mStat = 0;
    end else begin
      ev = 0;
      for (int i = 0; i < 8; i++) begin
        int need;
        need = (mPin[i][7:6] == 0) ? 0 : (1 << mPin[i][7:6]);
        if (mS2[i] == mLvl[i]) mCnt[i] = 0;
        else if (need == 0) begin
          ev[i] = mS2[i] ? mPin[i][5] : mPin[i][4];
          mLvl[i] = mS2[i];
        end else if (dbTick) begin
          if (mCnt[i] + 1 >= need) begin
            ev[i] = mS2[i] ? mPin[i][5] : mPin[i][4];
            mLvl[i] = mS2[i];
            mCnt[i] = 0;
          end else mCnt[i] = mCnt[i] + 1;
        end
      end
      if (busRd && busAddr == 8'hE8) mStat = 0;
      mStat = mStat | ev;
      if (busWr) begin
        if (busAddr >= 8'hE0 && busAddr <= 8'hE7) mPin[busAddr - 8'hE0] = busWdata & 8'hFB;
        else if (busAddr >= 8'hEC && busAddr <= 8'hF1) mSw[busAddr - 8'hEC] = busWdata & 8'h39;
        else if (busAddr == 8'hF4) mPlain = busWdata;
      end
      mS2 = mS1;
      mS1 = ioIn;
    end
  end

  function automatic logic [7:0] expRead();
    if (!busRd) return 0;
    if (busAddr >= 8'hE0 && busAddr <= 8'hE7) begin
      logic [7:0] v;
      v = mPin[busAddr - 8'hE0];
      v[2] = mLvl[busAddr - 8'hE0];
      return v;
    end
    if (busAddr == 8'hE8) return mStat;
    if (busAddr >= 8'hEC && busAddr <= 8'hF1) return mSw[busAddr - 8'hEC];
    if (busAddr == 8'hF4) return mPlain;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] eOe, eOut, eSo, eSe;
    logic [11:0] eStr;
    string t;
    for (int i = 0; i < 8; i++) begin
      eOe[i]  = mPin[i][0] & ~mPin[i][1];
      eOut[i] = mPin[i][3];
    end
    eSo = 0; eSe = 0;
    for (int i = 0; i < 6; i++) begin
      eSe[i] = mSw[i][0]; eSo[i] = mSw[i][3]; eStr[2*i +: 2] = mSw[i][5:4];
    end
    chk(rstN ? "R3" : "R1", "ioOe", ioOe, eOe);
    chk(rstN ? "R3" : "R1", "ioOut", ioOut, eOut);
    chk(rstN ? "R9" : "R1", "swOe", swOe, eSe[5:0]);
    chk(rstN ? "R9" : "R1", "swOut", swOut, eSo[5:0]);
    chk(rstN ? "R9" : "R1", "swStrength", swStrength, eStr);
    chk(rstN ? "R10" : "R1", "plainOut", plainOut, mPlain);
    chk(rstN ? "R8" : "R1", "irq", irq, mStat != 0);
    t = !rstN ? "R1" : (!busRd ? "R11" : curTag);
    chk(t, "busRdata", busRdata, expRead());
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1; step(); busWr = 0;
  endtask
  task automatic rd(logic [7:0] a);
    busAddr = a; busRd = 1; step(); busRd = 0;
  endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    curTag = "R1";
    idle(3);
    #1 rstN = 1;
    step();
    for (int a = 8'hE0; a <= 8'hF6; a++) rd(8'(a));

    // R2: layout and readback, bit 2 not writable
    curTag = "R2";
    for (int i = 0; i < 8; i++) wr(8'hE0 + 8'(i), 8'(8'h0F + 8'(i * 8'h11)) & 8'h3F);
    for (int i = 0; i < 8; i++) rd(8'hE0 + 8'(i));
    wr(8'hE2, 8'h04); rd(8'hE2);

    // R3: drive combinations
    curTag = "R3";
    wr(8'hE0, 8'h09); rd(8'hE0);
    wr(8'hE0, 8'h0B); rd(8'hE0);
    wr(8'hE0, 8'h01); rd(8'hE0);
    wr(8'hE0, 8'h08); rd(8'hE0);

    // R4 / R6: sync latency and edges, debounce 0
    curTag = "R4";
    for (int i = 0; i < 8; i++) wr(8'hE0 + 8'(i), 8'h02 | (i[0] ? 8'h20 : 8'h00) | (i[1] ? 8'h10 : 8'h00));
    ioIn = 8'hFF;
    for (int k = 0; k < 4; k++) rd(8'hE0);
    curTag = "R6";
    rd(8'hE8); rd(8'hE8);
    ioIn = 8'h00; idle(4);
    rd(8'hE8);
    ioIn = 8'h5A; idle(3); ioIn = 8'hA5; idle(3);
    rd(8'hE8);

    // R7: edge in the same cycle as a status read
    curTag = "R7";
    ioIn = 8'h0F; step(); step();
    rd(8'hE8);
    rd(8'hE8);
    wr(8'hE8, 8'hFF); rd(8'hE8);

    // R5: debounce with glitches and long holds
    curTag = "R5";
    ioIn = 8'h00; idle(4); rd(8'hE8);
    for (int s = 1; s < 4; s++) begin
      for (int i = 0; i < 8; i++) wr(8'hE0 + 8'(i), 8'(s << 6) | 8'h32);
      ioIn = 8'hFF; idle(2); ioIn = 8'h00; idle(6);
      ioIn = 8'hFF;
      for (int k = 0; k < 30; k++) rd(8'hE0 + 8'(k % 8));
      rd(8'hE8);
      ioIn = 8'h00;
      for (int k = 0; k < 30; k++) rd(8'hE0 + 8'(k % 8));
      rd(8'hE8);
    end

    // R9 / R10 / R11
    curTag = "R9";
    for (int i = 0; i < 6; i++) wr(8'hEC + 8'(i), 8'hFF - 8'(i * 8'h13));
    for (int i = 0; i < 6; i++) rd(8'hEC + 8'(i));
    curTag = "R10";
    wr(8'hF4, 8'hA5); rd(8'hF4); wr(8'hF4, 8'h3C); rd(8'hF4);
    curTag = "R11";
    wr(8'hE9, 8'hFF); wr(8'hF3, 8'hFF); wr(8'h00, 8'hFF); wr(8'hF5, 8'hFF);
    rd(8'hE9); rd(8'hEA); rd(8'hF2); rd(8'hF5); rd(8'h00); rd(8'hFF);
    for (int a = 8'hE0; a <= 8'hF6; a++) rd(8'(a));
    idle(3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule